// File: doc/BRIEF.md
# PS/2 Host Command Exchange Sequencer

This block runs one host-to-keyboard command exchange from start to finish. A request carries a command byte, an optional data byte (flagged by a separate presence bit), and the number of extra reply bytes the keyboard is expected to return after everything has been sent. The sequencer starts a byte transmitter for the command and then, if needed, for the data byte. Each time the transmitter finishes, it routes the frame receiver to itself. Every reply byte goes into a three-entry response buffer.

The exchange ends with a one-cycle done pulse, or with a one-cycle fail pulse if a resend code (0xFE) arrives or a reply does not come in time. While idle, the block follows the requested receive mode. During an exchange it holds on to the mode that was in force when the command started. When the exchange ends, it returns to that saved mode, so the device clock is released only if key reception was active before. Bit timing, framing and parity belong to the neighbouring transmitter and receiver.

Top module: `ps2_cmd_sequencer`

## Requirements
- R1: A start request while idle latches the command, data, data-present flag and extra count. From the next cycle, busy is high, all three response entries hold the NO_RESP marker, the response count is 0, and one tx_start pulse is issued with tx_byte equal to the command byte.
- R2: A start request while busy is ignored. The byte being transmitted and the exchange in progress are unchanged.
- R3: After tx_done, rx_answer is high from the next cycle and stays high while a reply is awaited.
- R4: Each accepted reply goes into entry number resp_cnt, and resp_cnt then increments. Entry i sits at resp bits [8i+7:8i]. Replies beyond the third are dropped, and the count stays at 3.
- R5: A reply of 0xFE ends the exchange at once with a fail pulse. No further transmission is started after it.
- R6: After a good reply to the command byte, the data byte is transmitted next if the data-present flag was set. If the flag was clear, no second transmission happens.
- R7: After the reply to the last sent byte, the block expects exactly extra more replies, with an extra value of 3 treated as 2. The done pulse comes on the edge that accepts the final reply.
- R8: done and fail are single-cycle pulses and are never high together. busy falls on the same edge that raises one of them.
- R9: While idle, key_mode equals the latched idle_mode_in and clk_inhibit is its inverse. During busy, both are low. In the first cycle after an exchange, they reflect the mode sampled at the start, whatever idle_mode_in did meanwhile.
- R10: If no reply arrives within TIMEOUT_CYC cycles of starting to wait for one, fail pulses. Unfilled entries stay at NO_RESP.
- R11: A reply strobe while no reply is awaited (idle, or while a byte is being transmitted) changes neither the response entries nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a command exchange |
| cmd_i | input | 8 | Command byte |
| data_i | input | 8 | Data byte |
| has_data_i | input | 1 | Data byte present |
| extra_i | input | 2 | Extra reply bytes expected (0..2, 3 acts as 2) |
| idle_mode_i | input | 1 | Receive mode while idle: 1 = key reception |
| tx_start_o | output | 1 | One-cycle request to the byte transmitter |
| tx_byte_o | output | 8 | Byte for the transmitter |
| tx_done_i | input | 1 | Transmitter finished the byte |
| rx_valid_i | input | 1 | Receiver has a byte |
| rx_byte_i | input | 8 | Received byte |
| rx_answer_o | output | 1 | Receiver output routed to this block |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | Exchange completed |
| fail_o | output | 1 | Exchange failed (resend code or timeout) |
| resp_o | output | 24 | Response entries, entry i at [8i+7:8i] |
| resp_cnt_o | output | 2 | Number of stored replies |
| key_mode_o | output | 1 | Key reception active |
| clk_inhibit_o | output | 1 | Hold the device clock low |

## Verification
A wrong phase in the state machine shows up at the ports on the very next edge. It appears as a missing or extra tx_start pulse, a tx_byte that holds the wrong byte, or a done pulse one reply early or late compared with the extra count. A corrupted response index shows as a reply in the wrong entry, or as a count that differs right after the strobe. A broken saved mode shows in the first idle cycle after done or fail. A miscounting timer moves the fail pulse away from exactly TIMEOUT_CYC cycles after the wait began. The sweep covers every combination of data presence, extra count, receive mode and the position of a resend reply.

// File: rtl/ps2seq_pkg.sv
// Shared definitions for the PS/2 command exchange sequencer.
// Assumes byte-wide replies; the resend code is fixed by the keyboard protocol.
package ps2seq_pkg;
    localparam logic [7:0] REPLY_RESEND = 8'hFE;
    localparam int         RESP_SLOTS   = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_TX_CMD,
        SQ_RX_CMD,
        SQ_TX_DAT,
        SQ_RX_DAT,
        SQ_RX_EXT
    } sq_state_t;
endpackage

// File: rtl/ps2seq_resp_buf.sv
// Response store: SLOTS byte entries filled in order, plus a fill count.
// Assumes clr and wr are never meaningful together (clr wins). Writes past
// the last entry are dropped and the count saturates at SLOTS.
module ps2seq_resp_buf #(
    parameter int         W       = 8,
    parameter int         SLOTS   = 3,
    parameter logic [7:0] NO_RESP = 8'h00,
    localparam int        CW      = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [W-1:0]         wr_byte,
    output logic [SLOTS*W-1:0]   resp_o,
    output logic [CW-1:0]        cnt_o
);
    logic [CW-1:0] cnt_q;

    // Fill count: cleared on start, steps on each stored reply up to SLOTS.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (wr && cnt_q < CW'(SLOTS)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [W-1:0] ent_q;
        // Entry i: reset to the marker, written when it is the next free one.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ent_q <= W'(NO_RESP);
            end else if (wr && cnt_q == CW'(i)) begin
                ent_q <= wr_byte;
            end
        end
        assign resp_o[i*W +: W] = ent_q;
    end

    assign cnt_o = cnt_q;

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && cnt_q < CW'(SLOTS)) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r4_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && cnt_q == CW'(SLOTS)) |=> $stable(resp_o));
endmodule

// File: rtl/ps2seq_reply_timer.sv
// Reply wait timer: counts cycles while enabled, restarts on clr or when
// disabled, and flags expiry in the LIMIT-th enabled cycle.
// Assumes LIMIT >= 2.
module ps2seq_reply_timer #(
    parameter int  LIMIT = 1_000_000,
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expired_o = en && (cnt_q == CNT_W'(LIMIT - 1));

    // Wait counter: held at zero outside a wait, parked at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r10_timer_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ps2seq_ctrl.sv
// Exchange state machine: sends the command, optionally the data byte,
// collects replies, aborts on the resend code or timeout, and holds the
// receive mode captured at start. Assumes tx_done_i and rx_valid_i are
// single-cycle strobes from the neighbouring transmitter and receiver.
module ps2seq_ctrl
    import ps2seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] cmd_i,
    input  logic [7:0] data_i,
    input  logic       has_data_i,
    input  logic [1:0] extra_i,
    input  logic       idle_mode_i,
    input  logic       tx_done_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       timeout_i,
    output logic       tx_start_o,
    output logic [7:0] tx_byte_o,
    output logic       rx_wait_o,
    output logic       accept_o,
    output logic       buf_clr_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o,
    output logic       key_mode_o,
    output logic       clk_inhibit_o
);
    sq_state_t  state_q;
    logic [7:0] cmd_q, data_q;
    logic       hasd_q, mode_q;
    logic [1:0] rem_q;
    logic       tx_start_q, done_q, fail_q;
    logic       ok_reply, bad_reply;

    // Decode the wait phase and classify an incoming reply.
    always_comb begin
        rx_wait_o = (state_q == SQ_RX_CMD) || (state_q == SQ_RX_DAT) ||
                    (state_q == SQ_RX_EXT);
        accept_o  = rx_wait_o && rx_valid_i;
        ok_reply  = accept_o && (rx_byte_i != REPLY_RESEND);
        bad_reply = accept_o && (rx_byte_i == REPLY_RESEND);
    end

    // Phase sequencing, request latching and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            cmd_q      <= '0;
            data_q     <= '0;
            hasd_q     <= 1'b0;
            rem_q      <= '0;
            mode_q     <= 1'b0;
            tx_start_q <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            tx_start_q <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            if (state_q == SQ_IDLE) begin
                mode_q <= idle_mode_i;
            end
            if (bad_reply || (rx_wait_o && !accept_o && timeout_i)) begin
                state_q <= SQ_IDLE;
                fail_q  <= 1'b1;
            end else begin
                case (state_q)
                    SQ_IDLE: if (start_i) begin
                        cmd_q      <= cmd_i;
                        data_q     <= data_i;
                        hasd_q     <= has_data_i;
                        rem_q      <= (extra_i == 2'd3) ? 2'd2 : extra_i;
                        state_q    <= SQ_TX_CMD;
                        tx_start_q <= 1'b1;
                    end
                    SQ_TX_CMD: if (tx_done_i) state_q <= SQ_RX_CMD;
                    SQ_TX_DAT: if (tx_done_i) state_q <= SQ_RX_DAT;
                    SQ_RX_CMD: if (ok_reply) begin
                        if (hasd_q) begin
                            state_q    <= SQ_TX_DAT;
                            tx_start_q <= 1'b1;
                        end else if (rem_q == 2'd0) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SQ_RX_EXT;
                        end
                    end
                    SQ_RX_DAT: if (ok_reply) begin
                        if (rem_q == 2'd0) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SQ_RX_EXT;
                        end
                    end
                    SQ_RX_EXT: if (ok_reply) begin
                        if (rem_q <= 2'd1) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            rem_q <= rem_q - 1'b1;
                        end
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    assign buf_clr_o     = (state_q == SQ_IDLE) && start_i;
    assign busy_o        = (state_q != SQ_IDLE);
    assign tx_start_o    = tx_start_q;
    assign tx_byte_o     = (state_q == SQ_TX_DAT) ? data_q : cmd_q;
    assign done_o        = done_q;
    assign fail_o        = fail_q;
    assign key_mode_o    = !busy_o && mode_q;
    assign clk_inhibit_o = !busy_o && !mode_q;

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && fail_q));
    a_r8_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_q || fail_q));
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(cmd_q) && $stable(data_q)));
    a_r5_resend_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        bad_reply |=> (fail_q && !tx_start_q && !busy_o));
    a_r1_tx_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_q |-> busy_o);
endmodule

// File: rtl/ps2_cmd_sequencer.sv
// Top level of the PS/2 command exchange sequencer: joins the state
// machine, the response store and the reply timer. Assumes a neighbouring
// byte transmitter and frame receiver with single-cycle strobes.
module ps2_cmd_sequencer
    import ps2seq_pkg::*;
#(
    parameter int         TIMEOUT_CYC = 1_000_000,
    parameter logic [7:0] NO_RESP     = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  cmd_i,
    input  logic [7:0]  data_i,
    input  logic        has_data_i,
    input  logic [1:0]  extra_i,
    input  logic        idle_mode_i,
    output logic        tx_start_o,
    output logic [7:0]  tx_byte_o,
    input  logic        tx_done_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_byte_i,
    output logic        rx_answer_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        fail_o,
    output logic [23:0] resp_o,
    output logic [1:0]  resp_cnt_o,
    output logic        key_mode_o,
    output logic        clk_inhibit_o
);
    logic rx_wait, accept, buf_clr, timeout;

    ps2seq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cmd_i         (cmd_i),
        .data_i        (data_i),
        .has_data_i    (has_data_i),
        .extra_i       (extra_i),
        .idle_mode_i   (idle_mode_i),
        .tx_done_i     (tx_done_i),
        .rx_valid_i    (rx_valid_i),
        .rx_byte_i     (rx_byte_i),
        .timeout_i     (timeout),
        .tx_start_o    (tx_start_o),
        .tx_byte_o     (tx_byte_o),
        .rx_wait_o     (rx_wait),
        .accept_o      (accept),
        .buf_clr_o     (buf_clr),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .fail_o        (fail_o),
        .key_mode_o    (key_mode_o),
        .clk_inhibit_o (clk_inhibit_o)
    );

    ps2seq_resp_buf #(.W(8), .SLOTS(RESP_SLOTS), .NO_RESP(NO_RESP)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (accept),
        .wr_byte (rx_byte_i),
        .resp_o  (resp_o),
        .cnt_o   (resp_cnt_o)
    );

    ps2seq_reply_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_wait),
        .clr       (accept),
        .expired_o (timeout)
    );

    assign rx_answer_o = rx_wait;

    a_r3_answer_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tx_done_i && !rx_answer_o) |=> rx_answer_o);
    a_r11_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(resp_cnt_o));
endmodule

// File: tb/tb_ps2_cmd_sequencer.sv
module tb_ps2_cmd_sequencer;
    localparam int         TO  = 64;
    localparam logic [7:0] NR  = 8'h00;
    localparam logic [7:0] FE  = 8'hFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, has_data_i = 1'b0, idle_mode_i = 1'b0;
    logic [7:0]  cmd_i = '0, data_i = '0, rx_byte_i = '0;
    logic [1:0]  extra_i = '0;
    logic        tx_done_i = 1'b0, rx_valid_i = 1'b0;
    logic        tx_start_o, rx_answer_o, busy_o, done_o, fail_o;
    logic        key_mode_o, clk_inhibit_o;
    logic [7:0]  tx_byte_o;
    logic [23:0] resp_o;
    logic [1:0]  resp_cnt_o;

    int checks = 0, bad = 0, cyc = 0, txn = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ps2_cmd_sequencer #(.TIMEOUT_CYC(TO), .NO_RESP(NR)) dut (.*);

    always @(negedge clk) if (tx_start_o) txn++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic wait_tx(input logic [7:0] exp_b, input string tag);
        for (int k = 0; k < 8 && !tx_start_o; k++) @(negedge clk);
        chk(tx_start_o === 1'b1, tag, 32'(tx_start_o), 1);
        chk(tx_byte_o == exp_b, tag, 32'(tx_byte_o), 32'(exp_b));
    endtask

    task automatic pulse_start(input logic [7:0] c, input logic [7:0] d,
                               input logic hd, input logic [1:0] ex, input logic md);
        idle_mode_i = md; cmd_i = c; data_i = d; has_data_i = hd; extra_i = ex;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_reply(input logic [7:0] b);
        rx_byte_i = b; rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic finish_tx();
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    // One exchange: hd data present, ex extra count, fpos resend reply index (-1 none).
    task automatic run(input bit hd, input int ex, input int fpos, input bit md, input bit poke);
        logic [7:0] rb [4];
        logic [7:0] c, d;
        int exe, nsent, total, last, txn0;
        logic [23:0] saved;
        c = 8'h20 + 8'(ex); d = 8'h40 + 8'(fpos + 2);
        exe = (ex == 3) ? 2 : ex;
        nsent = 1 + int'(hd);
        total = nsent + exe;
        for (int i = 0; i < 4; i++)
            rb[i] = (i == fpos) ? FE : ((i < nsent) ? 8'hFA : 8'hC0 + 8'(i));
        last = (fpos >= 0 && fpos < total) ? fpos : total - 1;
        @(negedge clk);
        txn0 = txn;
        pulse_start(c, d, hd, 2'(ex), md);
        chk(busy_o, "R1 busy", 32'(busy_o), 1);
        chk(resp_o == {3{NR}} && resp_cnt_o == 0, "R1 cleared", resp_o, {3{NR}});
        chk(!key_mode_o && !clk_inhibit_o, "R9 busy mode", {key_mode_o, clk_inhibit_o}, 0);
        idle_mode_i = !md;
        for (int i = 0; i <= last; i++) begin
            if (i < nsent) begin
                wait_tx((i == 0) ? c : d, (i == 0) ? "R1 tx cmd" : "R6 tx data");
                if (poke && i == 0) begin
                    cmd_i = 8'h77; data_i = 8'h66; start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                    chk(tx_byte_o == c && busy_o, "R2 start ignored", 32'(tx_byte_o), 32'(c));
                    send_reply(8'h33);
                    chk(resp_cnt_o == 0 && resp_o == {3{NR}}, "R11 strobe during tx",
                        32'(resp_cnt_o), 0);
                end
                @(negedge clk);
                finish_tx();
                chk(rx_answer_o, "R3 answer mode", 32'(rx_answer_o), 1);
            end else begin
                chk(rx_answer_o && busy_o, "R7 awaiting extra", {rx_answer_o, busy_o}, 3);
            end
            @(negedge clk);
            send_reply(rb[i]);
            if (i < last) begin
                chk(busy_o && !done_o && !fail_o, "R7 not yet over", {busy_o, done_o, fail_o}, 4);
                chk(resp_cnt_o == 2'((i + 1 > 3) ? 3 : i + 1), "R4 count", 32'(resp_cnt_o), i + 1);
            end
        end
        chk(fail_o == (rb[last] == FE), "R5 fail pulse", 32'(fail_o), 32'(rb[last] == FE));
        chk(done_o == (rb[last] != FE), "R7 done pulse", 32'(done_o), 32'(rb[last] != FE));
        chk(!busy_o, "R8 busy drops", 32'(busy_o), 0);
        chk(key_mode_o == md && clk_inhibit_o == !md, "R9 restore",
            {key_mode_o, clk_inhibit_o}, {md, !md});
        for (int k = 0; k < 3; k++)
            chk(resp_o[8*k +: 8] == ((k <= last) ? rb[k] : NR), "R4 entry",
                32'(resp_o[8*k +: 8]), 32'((k <= last) ? rb[k] : NR));
        chk(resp_cnt_o == 2'((last + 1 > 3) ? 3 : last + 1), "R4 final count",
            32'(resp_cnt_o), last + 1);
        saved = resp_o;
        @(negedge clk);
        chk(!done_o && !fail_o, "R8 single pulse", {done_o, fail_o}, 0);
        send_reply(8'h55);
        @(negedge clk);
        chk(resp_o == saved && !done_o && !fail_o, "R11 idle strobe", resp_o, saved);
        chk(txn - txn0 == ((fpos == 0) ? 1 : nsent), "R6 R5 tx count", txn - txn0,
            (fpos == 0) ? 1 : nsent);
    endtask

    // Timeout after n good replies to a command without data.
    task automatic run_to(input int ex, input int n);
        int w;
        @(negedge clk);
        pulse_start(8'h3C, 8'h00, 1'b0, 2'(ex), 1'b1);
        wait_tx(8'h3C, "R1 tx cmd");
        @(negedge clk);
        finish_tx();
        for (int i = 0; i < n; i++) send_reply((i == 0) ? 8'hFA : 8'hC0 + 8'(i));
        w = 0;
        while (!fail_o && w < TO + 20) begin
            @(negedge clk);
            w++;
        end
        chk(w == TO && fail_o && !done_o, "R10 timeout cycle", w, TO);
        chk(resp_cnt_o == 2'(n), "R10 count", 32'(resp_cnt_o), n);
        for (int k = 0; k < 3; k++)
            chk(resp_o[8*k +: 8] == ((k < n) ? ((k == 0) ? 8'hFA : 8'hC0 + 8'(k)) : NR),
                "R10 unfilled marker", 32'(resp_o[8*k +: 8]), 32'(NR));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !fail_o && !tx_start_o, "R8 reset idle",
            {busy_o, done_o, fail_o, tx_start_o}, 0);
        chk(resp_o == {3{NR}} && resp_cnt_o == 0, "R1 reset entries", resp_o, {3{NR}});
        chk(clk_inhibit_o && !key_mode_o, "R9 reset mode", {key_mode_o, clk_inhibit_o}, 1);
        rst_n = 1'b1;
        for (int md = 0; md < 2; md++)
            for (int hd = 0; hd < 2; hd++)
                for (int ex = 0; ex < 4; ex++) begin
                    int exe;
                    exe = (ex == 3) ? 2 : ex;
                    for (int fp = -1; fp < 1 + hd + exe; fp++)
                        run(bit'(hd), ex, fp, bit'(md), (ex == 1 && fp == -1));
                end
        run_to(0, 0);
        run_to(2, 1);
        run_to(2, 2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule